// File: doc/BRIEF.md
# Typed-Field Control and Status Register Bank

This block is a bank of eight 32-bit registers behind an AXI4-Lite slave port. Each register holds one or more bit fields. A field's access type decides two things: what the bus master sees when it reads or writes the field, and which user-side ports the field has. The user side of the chip connects to these ports.

The layout is fixed and is listed below by word index. A word's byte address is four times its index.
- Word 0 is a 32-bit status field. The bus can only read it.
- Word 1 is a 32-bit control field. An external clear input can reset it.
- Word 2 holds two fields: an 8-bit identity field in bits 7:0, which the bus can only read, and a 16-bit configuration field in bits 23:8.
- Word 3 is a 32-bit split field. Writes drive an output, and reads return a separate user input.
- Word 4 holds 8 sticky event flags in bits 7:0.
- Word 5 holds 8 self-clearing pulse bits in bits 7:0.
- Words 6 and 7 are unassigned. They read as zero and ignore writes.

A write is applied on the cycle after its address and data have both been accepted. The write response follows on the next cycle. Read data is captured when the read address is accepted.

Top module: `regbank_axil`

## Requirements
- R1: The write address and write data may arrive together, address first, or data first. Each write produces exactly one B response, and that response holds its value until `s_bready` is high.
- R2: Each accepted read address produces exactly one R response. `s_rvalid`, `s_rdata` and `s_rresp` hold steady until `s_rready` is high.
- R3: Write strobe bit n enables data bits 8n+7:8n. Byte lanes whose strobe is 0 keep their previous contents.
- R4: A transfer whose word index (address bits 7:2) is 8 or more gets response SLVERR (2'b10), reads as zero, and changes no field. Transfers to words 0 to 7 get OKAY (2'b00). Unassigned bits and words read as zero.
- R5: Word 0 reads `status_in`, and word 2 bits 7:0 read `id_in`. Bus writes to these fields have no effect.
- R6: Word 1 and word 2 bits 23:8 return the last value written to them. They drive `ctrl_out` and `cfg_out` from the stored value, one cycle after the write is applied.
- R7: When `ctrl_clr` is high at a clock edge, word 1 and `ctrl_out` become zero at that edge. The clear takes priority over a write applied in the same cycle.
- R8: A write to word 3 drives `split_out`. A read of word 3 returns `split_in`, not the written value.
- R9: Word 4 bit n is set at any edge where `event_in[n]` is 1, and then stays set. Writing 1 to the bit clears it. Writing 0 leaves it unchanged. If the input is 1 in the same cycle as a clear, the bit stays set.
- R10: Writing 1 to word 5 bit n drives `pulse_out[n]` high for exactly one cycle. Word 5 reads as zero. Writing 0, or writing with the strobe off, produces no pulse.
- R11: While `rst_n` is low, all stored fields, sticky flags, pulse outputs and response valids are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_awaddr | input | 8 | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 8 | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| status_in | input | 32 | Status value returned by word 0 |
| id_in | input | 8 | Identity value returned by word 2 bits 7:0 |
| ctrl_out | output | 32 | Stored control value of word 1 |
| ctrl_clr | input | 1 | Clears word 1 |
| cfg_out | output | 16 | Stored configuration value of word 2 bits 23:8 |
| split_out | output | 32 | Written value of word 3 |
| split_in | input | 32 | Readback value of word 3 |
| event_in | input | 8 | Event inputs captured into word 4 |
| pulse_out | output | 8 | One-cycle pulses from word 5 |

## Verification
The bench presents the address and data phases in all three orders. A slave that waited for a fixed order would hang, and one that reused stale data would store the wrong value. Partial strobes and writes to read-only or out-of-range words are checked against a bench model. This exposes lane mixing, writes leaking into read-only fields, and a missing SLVERR. The bench also checks corner cases in the special fields:
- A sticky flag written to clear while its input is still high must stay set. A design that let the clear win would drop that event.
- Pulse bits are counted cycle by cycle. A pulse that lasts two cycles, or a pulse produced by a zero write, is caught.
- A read of the split word must return the user input. A design that read back the stored value would fail this.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;

    typedef enum logic [1:0] {
        FK_RW     = 2'd0,
        FK_SPLIT  = 2'd1,
        FK_STICKY = 2'd2,
        FK_PULSE  = 2'd3
    } field_kind_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    localparam int REG_STATUS = 0;
    localparam int REG_CTRL   = 1;
    localparam int REG_MIX    = 2;
    localparam int REG_SPLIT  = 3;
    localparam int REG_EVENT  = 4;
    localparam int REG_PULSE  = 5;
    localparam int REG_USED   = 6;

    localparam int ID_LSB  = 0;
    localparam int ID_W    = 8;
    localparam int CFG_LSB = 8;
    localparam int CFG_W   = 16;
    localparam int EVT_W   = 8;
    localparam int PLS_W   = 8;
endpackage

// File: rtl/regbank_field.sv
module regbank_field
    import regbank_pkg::*;
#(
    parameter field_kind_e KIND    = FK_RW,
    parameter int          W       = 8,
    parameter bit          HAS_CLR = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] wr_be,
    input  logic [W-1:0] set_in,
    input  logic         clr_in,
    output logic [W-1:0] val
);
    typedef struct packed {
        logic [W-1:0] bits;
    } fstate_t;

    fstate_t state_d, state_q;
    logic [W-1:0] hit;

    always_comb begin
        state_d = state_q;
        hit     = wr_en ? (wr_data & wr_be) : '0;
        case (KIND)
            FK_RW, FK_SPLIT: begin
                if (wr_en) state_d.bits = (state_q.bits & ~wr_be) | (wr_data & wr_be);
                if (HAS_CLR && clr_in) state_d.bits = '0;
            end
            FK_STICKY: state_d.bits = (state_q.bits & ~hit) | set_in;
            FK_PULSE:  state_d.bits = hit;
            default:   state_d.bits = state_q.bits;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign val = state_q.bits;

    if (KIND == FK_PULSE) begin : g_pulse_chk
        // R10
        pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> (val == '0));
    end
    if (KIND == FK_STICKY) begin : g_sticky_chk
        // R9
        sticky_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_in != '0) |=> (($past(set_in) & ~val) == '0));
        // R9
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> (($past(val) & ~val) == '0));
    end
    if (KIND == FK_RW && HAS_CLR) begin : g_clr_chk
        // R7
        ext_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr_in |=> (val == '0));
    end
    if (KIND == FK_RW || KIND == FK_SPLIT) begin : g_hold_chk
        // R6
        rw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en && !(HAS_CLR && clr_in)) |=> $stable(val));
    end
endmodule

// File: rtl/regbank_axi_wr.sv
module regbank_axi_wr
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [STRB_W-1:0] wr_strb,
    input  logic              wr_ok
);
    typedef struct packed {
        logic              aw_full;
        logic [ADDR_W-1:0] addr;
        logic              w_full;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
        logic              b_valid;
        logic [1:0]        b_resp;
    } wstate_t;

    wstate_t wr_d, wr_q;

    always_comb begin
        wr_d      = wr_q;
        s_awready = !wr_q.aw_full && !wr_q.b_valid;
        s_wready  = !wr_q.w_full && !wr_q.b_valid;
        wr_en     = wr_q.aw_full && wr_q.w_full;
        if (s_awvalid && s_awready) begin
            wr_d.aw_full = 1'b1;
            wr_d.addr    = s_awaddr;
        end
        if (s_wvalid && s_wready) begin
            wr_d.w_full = 1'b1;
            wr_d.data   = s_wdata;
            wr_d.strb   = s_wstrb;
        end
        if (wr_en) begin
            wr_d.aw_full = 1'b0;
            wr_d.w_full  = 1'b0;
            wr_d.b_valid = 1'b1;
            wr_d.b_resp  = wr_ok ? RESP_OKAY : RESP_SLVERR;
        end
        if (wr_q.b_valid && s_bready) wr_d.b_valid = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    assign wr_addr  = wr_q.addr;
    assign wr_data  = wr_q.data;
    assign wr_strb  = wr_q.strb;
    assign s_bvalid = wr_q.b_valid;
    assign s_bresp  = wr_q.b_resp;

    // R1
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));
    // R1
    b_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> s_bvalid);
endmodule

// File: rtl/regbank_axi_rd.sv
module regbank_axi_rd
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              rd_ok
);
    typedef struct packed {
        logic              r_valid;
        logic [DATA_W-1:0] r_data;
        logic [1:0]        r_resp;
    } rstate_t;

    rstate_t rd_d, rd_q;

    always_comb begin
        rd_d      = rd_q;
        s_arready = !rd_q.r_valid;
        if (rd_q.r_valid && s_rready) rd_d.r_valid = 1'b0;
        if (s_arvalid && s_arready) begin
            rd_d.r_valid = 1'b1;
            rd_d.r_data  = rd_ok ? rd_word : '0;
            rd_d.r_resp  = rd_ok ? RESP_OKAY : RESP_SLVERR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign s_rvalid = rd_q.r_valid;
    assign s_rdata  = rd_q.r_data;
    assign s_rresp  = rd_q.r_resp;

    // R2
    r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp)));
    // R2
    ar_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> !s_arready);
endmodule

// File: rtl/regbank_axil.sv
module regbank_axil
    import regbank_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  logic [DATA_W-1:0] status_in,
    input  logic [ID_W-1:0]   id_in,
    output logic [DATA_W-1:0] ctrl_out,
    input  logic              ctrl_clr,
    output logic [CFG_W-1:0]  cfg_out,
    output logic [DATA_W-1:0] split_out,
    input  logic [DATA_W-1:0] split_in,
    input  logic [EVT_W-1:0]  event_in,
    output logic [PLS_W-1:0]  pulse_out
);
    localparam int IDX_W = ADDR_W - 2;

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [STRB_W-1:0] wr_strb;
    logic [DATA_W-1:0] wr_be;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic              wr_ok, rd_ok;
    logic [NUM_REGS-1:0] wr_sel;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] words [NUM_REGS];

    logic [DATA_W-1:0] ctrl_q, split_q;
    logic [CFG_W-1:0]  cfg_q;
    logic [EVT_W-1:0]  evt_q;
    logic [PLS_W-1:0]  pls_q;

    regbank_axi_wr #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
        .wr_ok(wr_ok)
    );

    regbank_axi_rd #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .rd_word(rd_word), .rd_ok(rd_ok)
    );

    assign wr_idx = wr_addr[ADDR_W-1:2];
    assign rd_idx = s_araddr[ADDR_W-1:2];
    assign wr_ok  = (int'(wr_idx) < NUM_REGS);
    assign rd_ok  = (int'(rd_idx) < NUM_REGS);

    for (genvar b = 0; b < STRB_W; b++) begin : g_be
        assign wr_be[b*8 +: 8] = {8{wr_strb[b]}};
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
        assign wr_sel[r] = wr_en && wr_ok && (wr_idx == IDX_W'(r));
    end

    regbank_field #(.KIND(FK_RW), .W(DATA_W), .HAS_CLR(1'b1)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[REG_CTRL]),
        .wr_data(wr_data), .wr_be(wr_be), .set_in('0), .clr_in(ctrl_clr), .val(ctrl_q)
    );

    regbank_field #(.KIND(FK_RW), .W(CFG_W), .HAS_CLR(1'b0)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[REG_MIX]),
        .wr_data(wr_data[CFG_LSB +: CFG_W]), .wr_be(wr_be[CFG_LSB +: CFG_W]),
        .set_in('0), .clr_in(1'b0), .val(cfg_q)
    );

    regbank_field #(.KIND(FK_SPLIT), .W(DATA_W), .HAS_CLR(1'b0)) u_split (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[REG_SPLIT]),
        .wr_data(wr_data), .wr_be(wr_be), .set_in('0), .clr_in(1'b0), .val(split_q)
    );

    regbank_field #(.KIND(FK_STICKY), .W(EVT_W), .HAS_CLR(1'b0)) u_evt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[REG_EVENT]),
        .wr_data(wr_data[EVT_W-1:0]), .wr_be(wr_be[EVT_W-1:0]),
        .set_in(event_in), .clr_in(1'b0), .val(evt_q)
    );

    regbank_field #(.KIND(FK_PULSE), .W(PLS_W), .HAS_CLR(1'b0)) u_pulse (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[REG_PULSE]),
        .wr_data(wr_data[PLS_W-1:0]), .wr_be(wr_be[PLS_W-1:0]),
        .set_in('0), .clr_in(1'b0), .val(pls_q)
    );

    assign ctrl_out  = ctrl_q;
    assign cfg_out   = cfg_q;
    assign split_out = split_q;
    assign pulse_out = pls_q;

    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) words[r] = '0;
        words[REG_STATUS]                   = status_in;
        words[REG_CTRL]                     = ctrl_q;
        words[REG_MIX][ID_LSB +: ID_W]      = id_in;
        words[REG_MIX][CFG_LSB +: CFG_W]    = cfg_q;
        words[REG_SPLIT]                    = split_in;
        words[REG_EVENT][EVT_W-1:0]         = evt_q;
        rd_word = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (rd_idx == IDX_W'(r)) rd_word = words[r];
        end
    end

    // R4
    bad_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_arvalid && s_arready && (int'(s_araddr[ADDR_W-1:2]) >= NUM_REGS))
        |=> (s_rresp == RESP_SLVERR && s_rdata == '0));
    // R10
    pulse_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_arvalid && s_arready && (int'(s_araddr[ADDR_W-1:2]) == REG_PULSE))
        |=> (s_rdata == '0));

    initial begin
        assert (NUM_REGS >= REG_USED && NUM_REGS <= (1 << IDX_W))
            else $error("register count does not fit the field layout");
    end
endmodule

// File: tb/regbank_axil_bench.sv
`timescale 1ns/1ps
module regbank_axil_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [7:0]  s_awaddr = '0;
    logic        s_awvalid = 1'b0, s_awready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_wvalid = 1'b0, s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid, s_bready = 1'b1;
    logic [7:0]  s_araddr = '0;
    logic        s_arvalid = 1'b0, s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid, s_rready = 1'b1;
    logic [31:0] status_in = '0;
    logic [7:0]  id_in = '0;
    logic [31:0] ctrl_out;
    logic        ctrl_clr = 1'b0;
    logic [15:0] cfg_out;
    logic [31:0] split_out;
    logic [31:0] split_in = '0;
    logic [7:0]  event_in = '0;
    logic [7:0]  pulse_out;

    regbank_axil u_regbank_axil (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .status_in(status_in), .id_in(id_in), .ctrl_out(ctrl_out), .ctrl_clr(ctrl_clr),
        .cfg_out(cfg_out), .split_out(split_out), .split_in(split_in),
        .event_in(event_in), .pulse_out(pulse_out)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model
    logic [31:0] ctrl_m = '0, split_m = '0;
    logic [15:0] cfg_m = '0;
    logic [7:0]  evt_m = '0;

    // pulse monitor
    logic pulse_clr = 1'b0;
    int   pulse_cnt [8];
    always @(negedge clk) begin
        for (int i = 0; i < 8; i++) begin
            if (pulse_clr) pulse_cnt[i] <= 0;
            else if (rst_n && pulse_out[i]) pulse_cnt[i] <= pulse_cnt[i] + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] strb_mask(input logic [3:0] s);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{s[b]}};
        return m;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] s);
        return (old & ~strb_mask(s)) | (d & strb_mask(s));
    endfunction

    function automatic logic [31:0] exp_read(input int idx);
        case (idx)
            0: return status_in;
            1: return ctrl_m;
            2: return {8'h00, cfg_m, id_in};
            3: return split_in;
            4: return {24'h0, evt_m};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [1:0] exp_resp(input int idx);
        return (idx < 8) ? 2'b00 : 2'b10;
    endfunction

    task automatic model_write(input int idx, input logic [31:0] d, input logic [3:0] s);
        logic [31:0] m;
        m = strb_mask(s);
        case (idx)
            1: ctrl_m = merge(ctrl_m, d, s);
            2: cfg_m  = (cfg_m & ~m[23:8]) | (d[23:8] & m[23:8]);
            3: split_m = merge(split_m, d, s);
            4: evt_m  = evt_m & ~(d[7:0] & m[7:0]);
            default: ;
        endcase
    endtask

    task automatic axi_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                             input int order, output logic [1:0] resp);
        bit aw_done, w_done;
        aw_done = 1'b0;
        w_done  = 1'b0;
        @(negedge clk);
        if (order != 2) begin s_awaddr = a; s_awvalid = 1'b1; end
        if (order != 1) begin s_wdata = d; s_wstrb = s; s_wvalid = 1'b1; end
        for (int n = 0; n < 40 && !(aw_done && w_done); n++) begin
            bit aw_go, w_go;
            aw_go = s_awvalid && s_awready;
            w_go  = s_wvalid && s_wready;
            @(negedge clk);
            if (aw_go) begin
                s_awvalid = 1'b0; aw_done = 1'b1;
                if (order == 1) begin s_wdata = d; s_wstrb = s; s_wvalid = 1'b1; end
            end
            if (w_go) begin
                s_wvalid = 1'b0; w_done = 1'b1;
                if (order == 2) begin s_awaddr = a; s_awvalid = 1'b1; end
            end
        end
        for (int n = 0; n < 40 && !s_bvalid; n++) @(negedge clk);
        resp = s_bresp;
        @(negedge clk);
    endtask

    task automatic axi_read(input logic [7:0] a, output logic [31:0] d, output logic [1:0] resp);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1'b1;
        for (int n = 0; n < 40 && !s_arready; n++) @(negedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        for (int n = 0; n < 40 && !s_rvalid; n++) @(negedge clk);
        d = s_rdata;
        resp = s_rresp;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        logic [1:0]  rs, ws;
        logic [31:0] held;
        void'($urandom(32'd5129));
        pulse_clr = 1'b1;

        repeat (3) @(negedge clk);
        // R11 reset state
        check(ctrl_out == 0 && cfg_out == 0 && split_out == 0, "R11 stored outputs in reset",
              ctrl_out | cfg_out | split_out, 0);
        check(pulse_out == 0 && !s_bvalid && !s_rvalid, "R11 pulses and valids in reset",
              {pulse_out, s_bvalid, s_rvalid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        pulse_clr = 1'b0;

        // R1 three orderings
        for (int ord = 0; ord < 3; ord++) begin
            logic [31:0] v;
            v = 32'h1111_0000 * (ord + 1) + 32'h0000_00A5;
            axi_write(8'h04, v, 4'hF, ord, ws);
            model_write(1, v, 4'hF);
            check(ws == 2'b00, "R1 write response per order", ws, 0);
            axi_read(8'h04, rd, rs);
            check(rd == ctrl_m, "R1 R6 readback per order", rd, ctrl_m);
            check(ctrl_out == ctrl_m, "R6 ctrl_out drives stored value", ctrl_out, ctrl_m);
        end

        // R3 byte strobes
        axi_write(8'h04, 32'hFFFF_FFFF, 4'hF, 0, ws); model_write(1, 32'hFFFF_FFFF, 4'hF);
        axi_write(8'h04, 32'h1234_5678, 4'b0101, 1, ws); model_write(1, 32'h1234_5678, 4'b0101);
        axi_read(8'h04, rd, rs);
        check(rd == 32'hFF34_FF78, "R3 partial strobe merge", rd, 32'hFF34_FF78);

        // R5 read-only fields ignore writes
        status_in = 32'hCAFE_0123; id_in = 8'h5C;
        axi_write(8'h00, 32'h0, 4'hF, 0, ws);
        axi_read(8'h00, rd, rs);
        check(rd == 32'hCAFE_0123, "R5 status readback after write", rd, 32'hCAFE_0123);
        axi_write(8'h08, 32'h00AB_CD00, 4'hF, 2, ws); model_write(2, 32'h00AB_CD00, 4'hF);
        axi_read(8'h08, rd, rs);
        check(rd == 32'h00AB_CD5C, "R5 R6 mixed word id and cfg", rd, 32'h00AB_CD5C);
        check(cfg_out == 16'hABCD, "R6 cfg_out", cfg_out, 16'hABCD);

        // R8 split readback
        split_in = 32'h0BAD_F00D;
        axi_write(8'h0C, 32'h7777_1234, 4'hF, 0, ws); model_write(3, 32'h7777_1234, 4'hF);
        axi_read(8'h0C, rd, rs);
        check(rd == 32'h0BAD_F00D, "R8 split read returns user input", rd, 32'h0BAD_F00D);
        check(split_out == 32'h7777_1234, "R8 split_out", split_out, 32'h7777_1234);

        // R7 external clear
        @(negedge clk); ctrl_clr = 1'b1;
        @(negedge clk); ctrl_clr = 1'b0;
        check(ctrl_out == 0, "R7 ctrl_out cleared", ctrl_out, 0);
        ctrl_m = '0;
        axi_read(8'h04, rd, rs);
        check(rd == 0, "R7 word 1 reads zero after clear", rd, 0);

        // R4 invalid addresses
        held = ctrl_out;
        axi_write(8'h24, 32'hDEAD_BEEF, 4'hF, 1, ws);
        check(ws == 2'b10, "R4 SLVERR on write beyond bank", ws, 2'b10);
        check(ctrl_out == held, "R4 bad write alters nothing", ctrl_out, held);
        axi_read(8'hFC, rd, rs);
        check(rs == 2'b10 && rd == 0, "R4 SLVERR and zero on bad read", {rd[29:0], rs}, 2'b10);
        axi_write(8'h18, 32'hFFFF_FFFF, 4'hF, 0, ws);
        axi_read(8'h18, rd, rs);
        check(rd == 0 && rs == 2'b00 && ws == 2'b00, "R4 unassigned word reads zero OKAY", rd, 0);

        // R9 sticky events
        @(negedge clk); event_in = 8'h24;
        @(negedge clk); event_in = 8'h00;
        evt_m = 8'h24;
        repeat (3) @(negedge clk);
        axi_read(8'h10, rd, rs);
        check(rd == 32'h24, "R9 sticky capture holds", rd, 32'h24);
        axi_write(8'h10, 32'h0, 4'hF, 0, ws);
        axi_read(8'h10, rd, rs);
        check(rd == 32'h24, "R9 writing 0 keeps flags", rd, 32'h24);
        event_in = 8'h04;
        axi_write(8'h10, 32'h24, 4'hF, 0, ws);
        axi_read(8'h10, rd, rs);
        check(rd == 32'h04, "R9 event during clear wins", rd, 32'h04);
        event_in = 8'h00;
        axi_write(8'h10, 32'h04, 4'hF, 2, ws);
        evt_m = 8'h00;
        axi_read(8'h10, rd, rs);
        check(rd == 0, "R9 write one clears", rd, 0);

        // R10 pulses
        pulse_clr = 1'b1; @(negedge clk); pulse_clr = 1'b0;
        axi_write(8'h14, 32'h81, 4'hF, 0, ws);
        repeat (4) @(negedge clk);
        check(pulse_cnt[0] == 1 && pulse_cnt[7] == 1, "R10 one-cycle pulse on set bits",
              pulse_cnt[0] + pulse_cnt[7], 2);
        check(pulse_cnt[1] + pulse_cnt[3] + pulse_cnt[6] == 0, "R10 no pulse on zero bits",
              pulse_cnt[1] + pulse_cnt[3] + pulse_cnt[6], 0);
        pulse_clr = 1'b1; @(negedge clk); pulse_clr = 1'b0;
        axi_write(8'h14, 32'h00, 4'hF, 1, ws);
        axi_write(8'h14, 32'hFF, 4'hE, 2, ws);
        repeat (4) @(negedge clk);
        begin
            int tot;
            tot = 0;
            for (int i = 0; i < 8; i++) tot += pulse_cnt[i];
            check(tot == 0, "R10 zero write or strobe off gives no pulse", tot, 0);
        end
        axi_read(8'h14, rd, rs);
        check(rd == 0, "R10 pulse word reads zero", rd, 0);

        // R2 held read response
        @(negedge clk); s_rready = 1'b0;
        s_araddr = 8'h04; s_arvalid = 1'b1;
        @(negedge clk); s_arvalid = 1'b0;
        held = s_rdata;
        repeat (3) @(negedge clk);
        check(s_rvalid && s_rdata == held && held == ctrl_m, "R2 read response held", s_rdata, ctrl_m);
        s_rready = 1'b1;
        @(negedge clk);
        check(!s_rvalid, "R2 single response then idle", s_rvalid, 0);

        // R1 held write response
        s_bready = 1'b0;
        @(negedge clk);
        s_awaddr = 8'h44; s_awvalid = 1'b1; s_wdata = 0; s_wstrb = 4'hF; s_wvalid = 1'b1;
        @(negedge clk); s_awvalid = 1'b0; s_wvalid = 1'b0;
        repeat (4) @(negedge clk);
        check(s_bvalid && s_bresp == 2'b10, "R1 B held until ready", {s_bvalid, s_bresp}, 3'b110);
        s_bready = 1'b1;
        @(negedge clk);
        check(!s_bvalid, "R1 one B per write", s_bvalid, 0);

        // random mix (R1 R3 R4 R5 R6 R8)
        for (int it = 0; it < 300; it++) begin
            int idx, ord;
            logic [31:0] d;
            logic [3:0] s;
            idx = $urandom_range(0, 9);
            if (idx == 5) idx = 6;
            if (idx >= 8) idx = $urandom_range(8, 63);
            d = $urandom();
            s = 4'($urandom_range(0, 15));
            ord = $urandom_range(0, 2);
            status_in = $urandom();
            id_in = 8'($urandom());
            split_in = $urandom();
            if ($urandom_range(0, 1) == 1) begin
                axi_write(8'(idx * 4), d, s, ord, ws);
                model_write(idx, d, s);
                check(ws == exp_resp(idx), "R1 R4 random write response", ws, exp_resp(idx));
            end else begin
                axi_read(8'(idx * 4), rd, rs);
                check(rd == exp_read(idx) && rs == exp_resp(idx), "R3 R5 R6 R8 random read",
                      rd, exp_read(idx));
            end
        end
        check(ctrl_out == ctrl_m && cfg_out == cfg_m && split_out == split_m,
              "R6 R8 outputs after random phase", ctrl_out, ctrl_m);

        done = 1'b1;
        finish_run();
    end
endmodule